// File: doc/BRIEF.md
# Secure Real-Time Clock Register Block

This block is a memory-mapped real-time clock behind a simple 32-bit register bus. It keeps a 32-bit seconds count with a sub-second prescaler fed by a one-bit tick input. It compares the seconds count against an alarm value, and it reports events through one status word. Every flag in that word is gated by its own enable bit onto a single interrupt line.

Writes are posted. Each accepted write opens a short posting window during which the block reports itself busy. When the window closes, a completion flag tells software the write has landed. A write that arrives while the block is busy, or that targets no register, is dropped and raises an error flag. Software can therefore issue one write and then wait for either flag, polling or by interrupt. The event flags are cleared by writing ones to them. After reset an invalid-state flag is held, and software clears it during bring-up.

Top module: `rtc_vault`

## Requirements
- R1: After reset the seconds count, sub-second count, control and interrupt enable read 0. The alarm (0x08) reads 0xFFFFFFFF. Status (0x14) reads 0x00000002, with only the invalid-state bit 1 set. The interrupt output is low.
- R2: The counter runs only while control (0x10) bit 3 is 1. In that state, each cycle with the tick input high adds one to the sub-second count (0x04, low 15 bits). When the sub-second count wraps from 32767 to 0, the seconds count (0x00) increases by one.
- R3: Writing 0x00 loads the seconds count and clears the sub-second count. Writing 0x04 loads the sub-second count from write data bits 14:0.
- R4: An accepted write sets status bit 10 (busy) and bit 9 (write pending) for the 4 cycles after it. When the window closes, status bit 8 (write done) sets and bits 10 and 9 clear. The exception is a write to the status register itself, which never sets bit 8.
- R5: A write is rejected if it arrives while bit 10 is set, or if it targets an address other than 0x00, 0x04, 0x08, 0x0C, 0x10, 0x14 or 0x18. A rejected write changes no register, opens no window, and sets status bit 7 (write error) on the next cycle.
- R6: Writing 1 to status bits 8, 7, 4, 1 or 0 clears that flag. Writing 0 leaves it unchanged.
- R7: Write done (bit 8) clears in the cycle after any accepted write.
- R8: Status bit 4 (alarm) sets one cycle after the seconds count equals the alarm register, unless the alarm holds 0xFFFFFFFF. If a set and a clear of this flag fall in the same cycle, the set wins.
- R9: The interrupt output is high when any of status bits 9, 8, 7 or 4 is set together with the same bit of the enable register (0x18). It drops in the cycle after the matching enable bit is written to 0.
- R10: The alarm companion register (0x0C) stores and returns a 32-bit value and has no effect on alarm matching.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and counter clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_in | input | 1 | Sub-second tick, one count per high cycle |
| bus_addr | input | 5 | Byte address of the register accessed |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq_out | output | 1 | Combined, enabled interrupt request |

## Verification
The alarm match and a software write-one-to-clear of the alarm flag can land on the same clock edge. This happens when the seconds count is parked on the alarm value while software clears the flag. The bench provokes it by stopping the counter, loading equal seconds and alarm values, and then writing 0x10 to the status register. It judges the result by reading the flag back as still set. It then moves the seconds count off the alarm value and checks that the same clear now takes effect.

// File: rtl/rtc_vault_pkg.sv
package rtc_vault_pkg;

    localparam int REG_W  = 32;
    localparam int ADDR_W = 5;

    localparam logic [ADDR_W-1:0] OFF_SEC    = 5'h00;
    localparam logic [ADDR_W-1:0] OFF_SUB    = 5'h04;
    localparam logic [ADDR_W-1:0] OFF_ALM    = 5'h08;
    localparam logic [ADDR_W-1:0] OFF_ALMSUB = 5'h0C;
    localparam logic [ADDR_W-1:0] OFF_CTRL   = 5'h10;
    localparam logic [ADDR_W-1:0] OFF_STAT   = 5'h14;
    localparam logic [ADDR_W-1:0] OFF_IEN    = 5'h18;

    localparam int BIT_BUSY = 10;
    localparam int BIT_PEND = 9;
    localparam int BIT_DONE = 8;
    localparam int BIT_ERR  = 7;
    localparam int BIT_ALM  = 4;
    localparam int BIT_NV   = 1;
    localparam int BIT_SV   = 0;
    localparam int BIT_RUN  = 3;

    localparam logic [REG_W-1:0] IRQ_MASK = (REG_W'(1) << BIT_PEND) | (REG_W'(1) << BIT_DONE)
                                          | (REG_W'(1) << BIT_ERR)  | (REG_W'(1) << BIT_ALM);

    typedef enum logic [2:0] {
        SEL_SEC, SEL_SUB, SEL_ALM, SEL_ALMSUB, SEL_CTRL, SEL_STAT, SEL_IEN, SEL_NONE
    } reg_sel_e;

    function automatic reg_sel_e decode_addr(input logic [ADDR_W-1:0] a);
        reg_sel_e s;
        case (a)
            OFF_SEC:    s = SEL_SEC;
            OFF_SUB:    s = SEL_SUB;
            OFF_ALM:    s = SEL_ALM;
            OFF_ALMSUB: s = SEL_ALMSUB;
            OFF_CTRL:   s = SEL_CTRL;
            OFF_STAT:   s = SEL_STAT;
            OFF_IEN:    s = SEL_IEN;
            default:    s = SEL_NONE;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/rtc_vault_timebase.sv
module rtc_vault_timebase #(
    parameter int SEC_W = 32,
    parameter int SUB_W = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             tick,
    input  logic             ld_sec,
    input  logic             ld_sub,
    input  logic [SEC_W-1:0] wdata,
    output logic [SEC_W-1:0] sec_o,
    output logic [SUB_W-1:0] sub_o
);

    localparam logic [SUB_W-1:0] SUB_ONE = SUB_W'(1);
    localparam logic [SEC_W-1:0] SEC_ONE = SEC_W'(1);

    typedef struct packed {
        logic [SEC_W-1:0] sec;
        logic [SUB_W-1:0] sub;
    } tb_state_t;

    tb_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (ld_sec) begin
            st_d.sec = wdata;
            st_d.sub = '0;
        end else if (ld_sub) begin
            st_d.sub = wdata[SUB_W-1:0];
        end else if (run && tick) begin
            st_d.sub = st_q.sub + SUB_ONE;
            if (st_q.sub == {SUB_W{1'b1}}) begin
                st_d.sec = st_q.sec + SEC_ONE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sec_o = st_q.sec;
    assign sub_o = st_q.sub;

endmodule

// File: rtl/rtc_vault_poster.sv
module rtc_vault_poster #(
    parameter int WIN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    input  logic to_stat,
    output logic accept,
    output logic busy,
    output logic done
);

    localparam int CW = $clog2(WIN + 1);
    localparam logic [CW-1:0] CNT_LOAD = CW'(WIN);
    localparam logic [CW-1:0] CNT_ONE  = CW'(1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          stat_tgt;
    } post_state_t;

    post_state_t ps_d, ps_q;

    always_comb begin
        busy   = (ps_q.cnt != '0);
        accept = req && !busy;
        done   = (ps_q.cnt == CNT_ONE) && !ps_q.stat_tgt;
        ps_d   = ps_q;
        if (accept) begin
            ps_d.cnt      = CNT_LOAD;
            ps_d.stat_tgt = to_stat;
        end else if (busy) begin
            ps_d.cnt = ps_q.cnt - CNT_ONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ps_q <= '0;
        end else begin
            ps_q <= ps_d;
        end
    end

endmodule

// File: rtl/rtc_vault_alarm.sv
module rtc_vault_alarm #(
    parameter int SEC_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld_alm,
    input  logic             ld_almsub,
    input  logic [SEC_W-1:0] wdata,
    input  logic [SEC_W-1:0] sec,
    output logic [SEC_W-1:0] alm_o,
    output logic [SEC_W-1:0] almsub_o,
    output logic             hit_o
);

    typedef struct packed {
        logic [SEC_W-1:0] alm;
        logic [SEC_W-1:0] almsub;
    } alm_state_t;

    alm_state_t as_d, as_q;

    always_comb begin
        as_d = as_q;
        if (ld_alm) begin
            as_d.alm = wdata;
        end
        if (ld_almsub) begin
            as_d.almsub = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            as_q.alm    <= '1;
            as_q.almsub <= '0;
        end else begin
            as_q <= as_d;
        end
    end

    assign alm_o    = as_q.alm;
    assign almsub_o = as_q.almsub;
    assign hit_o    = (as_q.alm != {SEC_W{1'b1}}) && (sec == as_q.alm);

endmodule

// File: rtl/rtc_vault.sv
module rtc_vault
    import rtc_vault_pkg::*;
#(
    parameter int SUB_W    = 15,
    parameter int POST_WIN = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_in,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    output logic              irq_out
);

    typedef struct packed {
        logic             run;
        logic [REG_W-1:0] ien;
        logic             done;
        logic             err;
        logic             alm;
        logic             nv;
        logic             sv;
    } top_state_t;

    top_state_t regs_d, regs_q;

    reg_sel_e         sel;
    logic             mapped;
    logic             accept;
    logic             busy;
    logic             done_ev;
    logic             run_en;
    logic [REG_W-1:0] ien_w;
    logic [REG_W-1:0] stat_vec;
    logic [REG_W-1:0] sec_w;
    logic [SUB_W-1:0] sub_w;
    logic [REG_W-1:0] alm_w;
    logic [REG_W-1:0] almsub_w;
    logic             alm_hit;
    logic             stat_wr;

    assign sel    = decode_addr(bus_addr);
    assign mapped = (sel != SEL_NONE);
    assign run_en = regs_q.run;
    assign ien_w  = regs_q.ien;

    rtc_vault_poster #(.WIN(POST_WIN)) u_poster (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (bus_we && mapped),
        .to_stat (sel == SEL_STAT),
        .accept  (accept),
        .busy    (busy),
        .done    (done_ev)
    );

    rtc_vault_timebase #(.SEC_W(REG_W), .SUB_W(SUB_W)) u_timebase (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (run_en),
        .tick   (tick_in),
        .ld_sec (accept && (sel == SEL_SEC)),
        .ld_sub (accept && (sel == SEL_SUB)),
        .wdata  (bus_wdata),
        .sec_o  (sec_w),
        .sub_o  (sub_w)
    );

    rtc_vault_alarm #(.SEC_W(REG_W)) u_alarm (
        .clk       (clk),
        .rst_n     (rst_n),
        .ld_alm    (accept && (sel == SEL_ALM)),
        .ld_almsub (accept && (sel == SEL_ALMSUB)),
        .wdata     (bus_wdata),
        .sec       (sec_w),
        .alm_o     (alm_w),
        .almsub_o  (almsub_w),
        .hit_o     (alm_hit)
    );

    assign stat_wr = accept && (sel == SEL_STAT);

    always_comb begin
        regs_d = regs_q;

        if (accept && (sel == SEL_CTRL)) begin
            regs_d.run = bus_wdata[BIT_RUN];
        end
        if (accept && (sel == SEL_IEN)) begin
            regs_d.ien = bus_wdata & IRQ_MASK;
        end

        // write done: cleared by any accepted write, set when a window closes
        if (accept) begin
            regs_d.done = 1'b0;
        end else if (done_ev) begin
            regs_d.done = 1'b1;
        end

        // write-one-to-clear, event set has priority
        if (stat_wr && bus_wdata[BIT_ERR]) regs_d.err = 1'b0;
        if (stat_wr && bus_wdata[BIT_ALM]) regs_d.alm = 1'b0;
        if (stat_wr && bus_wdata[BIT_NV])  regs_d.nv  = 1'b0;
        if (stat_wr && bus_wdata[BIT_SV])  regs_d.sv  = 1'b0;

        if (bus_we && !accept) regs_d.err = 1'b1;
        if (alm_hit)           regs_d.alm = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q    <= '0;
            regs_q.nv <= 1'b1;
        end else begin
            regs_q <= regs_d;
        end
    end

    always_comb begin
        stat_vec           = '0;
        stat_vec[BIT_BUSY] = busy;
        stat_vec[BIT_PEND] = busy;
        stat_vec[BIT_DONE] = regs_q.done;
        stat_vec[BIT_ERR]  = regs_q.err;
        stat_vec[BIT_ALM]  = regs_q.alm;
        stat_vec[BIT_NV]   = regs_q.nv;
        stat_vec[BIT_SV]   = regs_q.sv;
    end

    assign irq_out = |(stat_vec & ien_w & IRQ_MASK);

    always_comb begin
        bus_rdata = '0;
        case (sel)
            SEL_SEC:    bus_rdata = sec_w;
            SEL_SUB:    bus_rdata = {{(REG_W-SUB_W){1'b0}}, sub_w};
            SEL_ALM:    bus_rdata = alm_w;
            SEL_ALMSUB: bus_rdata = almsub_w;
            SEL_CTRL:   bus_rdata[BIT_RUN] = run_en;
            SEL_STAT:   bus_rdata = stat_vec;
            SEL_IEN:    bus_rdata = ien_w;
            default:    bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/rtc_vault_chk.sv
module rtc_vault_chk #(
    parameter int SUB_W = 15
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_we,
    input logic             irq_out,
    input logic             busy,
    input logic             run,
    input logic [31:0]      sec,
    input logic [SUB_W-1:0] sub,
    input logic [31:0]      alm,
    input logic [31:0]      stat,
    input logic [31:0]      ien
);

    // R5: a write arriving during the posting window leaves the error flag set
    a_r5_busy_write_errors: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && busy) |=> stat[7]);

    // R4: write done only appears as the posting window closes
    a_r4_done_at_window_end: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat[8]) |-> $fell(busy));

    // R2: with the counter stopped and no write, time stands still
    a_r2_frozen_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !bus_we) |=> ($stable(sec) && $stable(sub)));

    // R8: an armed match raises the alarm flag on the next cycle
    a_r8_match_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
        ((sec == alm) && (alm != 32'hFFFF_FFFF)) |=> stat[4]);

    // R8: the unset pattern never raises the flag
    a_r8_unset_is_silent: assert property (@(posedge clk) disable iff (!rst_n)
        ((alm == 32'hFFFF_FFFF) && !stat[4]) |=> !stat[4]);

    // R9: with every source disabled the line stays low
    a_r9_quiet_when_masked: assert property (@(posedge clk) disable iff (!rst_n)
        ((ien & 32'h0000_0390) == 32'h0) |-> !irq_out);

endmodule

bind rtc_vault rtc_vault_chk #(.SUB_W(SUB_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .bus_we  (bus_we),
    .irq_out (irq_out),
    .busy    (busy),
    .run     (run_en),
    .sec     (sec_w),
    .sub     (sub_w),
    .alm     (alm_w),
    .stat    (stat_vec),
    .ien     (ien_w)
);

// File: tb/rtc_vault_bench.sv
module rtc_vault_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_in = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_out;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    rtc_vault u_rtc_vault (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_in   (tick_in),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_out   (irq_out)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] v);
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    task automatic wr_raw(input logic [4:0] a, input logic [31:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_we    = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        wr_raw(a, d);
        repeat (4) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(5'h00, v); chk("R1 seconds", v, 32'h0);
        rd(5'h04, v); chk("R1 subsec", v, 32'h0);
        rd(5'h08, v); chk("R1 alarm", v, 32'hFFFF_FFFF);
        rd(5'h10, v); chk("R1 control", v, 32'h0);
        rd(5'h14, v); chk("R1 status", v, 32'h2);
        rd(5'h18, v); chk("R1 enable", v, 32'h0);
        chk("R1 irq", {31'h0, irq_out}, 32'h0);
    endtask

    task automatic t_w1c();
        logic [31:0] v;
        wr(5'h14, 32'h0);
        rd(5'h14, v); chk("R6 zero write keeps invalid flag", v, 32'h2);
        wr(5'h14, 32'h2);
        rd(5'h14, v); chk("R6 one clears invalid, no done for status write", v, 32'h0);
    endtask

    task automatic t_posting();
        logic [31:0] v;
        wr_raw(5'h10, 32'h0);
        rd(5'h14, v); chk("R4 window opens", v & 32'h700, 32'h600);
        repeat (3) @(negedge clk);
        rd(5'h14, v); chk("R4 window last cycle", v & 32'h700, 32'h600);
        @(negedge clk);
        rd(5'h14, v); chk("R4 done after window", v & 32'h700, 32'h100);
        wr_raw(5'h18, 32'h0);
        rd(5'h14, v); chk("R7 done cleared by next write", v & 32'h700, 32'h600);
        repeat (4) @(negedge clk);
    endtask

    task automatic t_reject();
        logic [31:0] v;
        wr_raw(5'h0C, 32'hA5A5_0001);
        wr_raw(5'h0C, 32'h5A5A_0002);
        rd(5'h14, v); chk("R5 busy write sets error", v & 32'h080, 32'h080);
        repeat (3) @(negedge clk);
        rd(5'h0C, v); chk("R5 R10 rejected write dropped", v, 32'hA5A5_0001);
        wr(5'h14, 32'h80);
        rd(5'h14, v); chk("R6 error cleared", v & 32'h1F3, 32'h0);
        wr_raw(5'h1C, 32'h1);
        rd(5'h14, v); chk("R5 unmapped write errors without window", v & 32'h680, 32'h080);
        @(negedge clk);
        wr(5'h14, 32'h80);
        rd(5'h14, v); chk("R6 error cleared again", v & 32'h080, 32'h0);
    endtask

    task automatic t_counter();
        logic [31:0] v;
        wr(5'h00, 32'd100);
        wr(5'h04, 32'd32766);
        rd(5'h04, v); chk("R3 subsec load", v, 32'd32766);
        tick_in = 1'b1;
        repeat (3) @(negedge clk);
        tick_in = 1'b0;
        rd(5'h04, v); chk("R2 stopped counter ignores ticks", v, 32'd32766);
        wr(5'h10, 32'h8);
        rd(5'h10, v); chk("R2 run bit readback", v, 32'h8);
        tick_in = 1'b1;
        repeat (2) @(negedge clk);
        tick_in = 1'b0;
        rd(5'h04, v); chk("R2 subsec wrapped", v, 32'd0);
        rd(5'h00, v); chk("R2 seconds carried", v, 32'd101);
        tick_in = 1'b1;
        @(negedge clk);
        tick_in = 1'b0;
        repeat (2) @(negedge clk);
        rd(5'h04, v); chk("R2 single tick", v, 32'd1);
        wr(5'h10, 32'h0);
        tick_in = 1'b1;
        repeat (3) @(negedge clk);
        tick_in = 1'b0;
        rd(5'h04, v); chk("R2 halted after disable", v, 32'd1);
        wr(5'h00, 32'h0000_1234);
        rd(5'h00, v); chk("R3 seconds load", v, 32'h0000_1234);
        rd(5'h04, v); chk("R3 seconds load clears subsec", v, 32'd0);
    endtask

    task automatic t_alarm();
        logic [31:0] v;
        wr(5'h08, 32'd50);
        rd(5'h14, v); chk("R8 no alarm before match", v & 32'h10, 32'h0);
        wr(5'h00, 32'd50);
        rd(5'h14, v); chk("R8 alarm on match", v & 32'h10, 32'h10);
        wr(5'h14, 32'h10);
        rd(5'h14, v); chk("R8 set wins over clear", v & 32'h10, 32'h10);
        wr(5'h00, 32'd51);
        wr(5'h14, 32'h10);
        rd(5'h14, v); chk("R6 R8 alarm cleared off match", v & 32'h10, 32'h0);
        wr(5'h0C, 32'd51);
        rd(5'h14, v); chk("R10 companion does not match", v & 32'h10, 32'h0);
        wr(5'h08, 32'hFFFF_FFFF);
        wr(5'h00, 32'hFFFF_FFFF);
        rd(5'h14, v); chk("R8 unset value never fires", v & 32'h10, 32'h0);
    endtask

    task automatic t_irq();
        logic [31:0] v;
        wr(5'h08, 32'd60);
        wr(5'h00, 32'd60);
        chk("R9 masked alarm quiet", {31'h0, irq_out}, 32'h0);
        wr(5'h18, 32'h10);
        chk("R9 enabled alarm raises irq", {31'h0, irq_out}, 32'h1);
        wr_raw(5'h18, 32'h0);
        chk("R9 disable drops irq at once", {31'h0, irq_out}, 32'h0);
        rd(5'h14, v); chk("R9 alarm flag still held", v & 32'h10, 32'h10);
        repeat (4) @(negedge clk);
        wr(5'h18, 32'h100);
        chk("R9 done source raises irq", {31'h0, irq_out}, 32'h1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_w1c();
        t_posting();
        t_reject();
        t_counter();
        t_alarm();
        t_irq();
        if (!finished) begin
            finished = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog got timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule